// File: doc/BRIEF.md
# Pulse Accumulator Counter Unit

This block is a 16-bit accumulator fed by one asynchronous input pin. The pin first passes through a two-flop synchronizer, and edge detection works on the synchronized value. A mode bit picks one of two uses for the counter.

In edge-counting mode, every transition of the selected polarity adds one to the count. In gated mode, the count advances once per 64 module clocks while the pin stays at its selected active level and the timer is enabled.

Two sticky flags record events. The input flag marks a counted edge in edge mode, or the end of a gate pulse in gated mode. The rollover flag marks a wrap of the counter. Each flag is cleared by pulsing a write-one strobe, and each one drives an interrupt request through its own enable. Software can load the count directly through a write strobe.

Top module: `pulse_acc`

## Requirements
- R1: After reset, `count` is 0 and `flag_in`, `flag_ovf`, `irq_in` and `irq_ovf` are all 0.
- R2: With `mode_gate`=0, `count` rises by exactly one for each synchronized rising edge of `pin_in` when `pol_sel`=1, or for each falling edge when `pol_sel`=0. Edges of the other polarity do not change the count. This works whatever the value of `tmr_en`.
- R3: With `mode_gate`=0, every counted edge sets `flag_in`.
- R4: When the counter steps from 0xFFFF to 0x0000, `flag_ovf` is set in the same clock as the wrap.
- R5: With `mode_gate`=1, `count` rises by one every 64 module clocks while `tmr_en`=1 and the synchronized pin is at its active level. The active level is high when `pol_sel`=1 and low when `pol_sel`=0. The first step comes 64 clocks after `tmr_en` rises. The count holds while `tmr_en`=0 or while the gate is inactive.
- R6: With `mode_gate`=1, `flag_in` is set on the trailing edge of a gate pulse: a falling edge when `pol_sel`=1, or a rising edge when `pol_sel`=0.
- R7: A high on `clr_in` or `clr_ovf` for one clock clears the matching flag. If a set event lands in the same clock as the clear, the flag stays set.
- R8: A high on `cnt_wr` loads `cnt_wdata` into the count at the next edge. The load takes priority over any increment in that clock and never sets `flag_ovf`.
- R9: While `acc_en`=0, the count holds its value (unless a load is made) and no flag is set.
- R10: `irq_in` is high exactly when `flag_in` is high and `ie_in` was high at the same clock edge. `irq_ovf` follows the same rule with `flag_ovf` and `ie_ovf`.
- R11: In edge mode, a change on `pin_in` made between clock edges shows in `count` after the third following rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| acc_en | input | 1 | Accumulator enable |
| mode_gate | input | 1 | 0 = edge counting, 1 = gated time accumulation |
| pol_sel | input | 1 | Edge mode: 1 rising / 0 falling; gated mode: 1 high / 0 low active |
| ie_in | input | 1 | Input-flag interrupt enable |
| ie_ovf | input | 1 | Rollover interrupt enable |
| tmr_en | input | 1 | Timer enable; gates the prescaler in gated mode |
| cnt_wr | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Value to load into the count |
| clr_in | input | 1 | Write-one clear for the input flag |
| clr_ovf | input | 1 | Write-one clear for the rollover flag |
| count | output | 16 | Current accumulator value |
| flag_in | output | 1 | Input event flag |
| flag_ovf | output | 1 | Rollover flag |
| irq_in | output | 1 | Input interrupt request |
| irq_ovf | output | 1 | Rollover interrupt request |

## Verification
A corrupted synchronizer or edge history appears as a missed or doubled count, or as a count that changes one clock off its expected edge. The bench checks for both by sampling exactly three edges after each pin change.

A prescaler that is off by one or free-running shows only in gated mode. It appears within 64 clocks as a count that is one higher or lower than expected, or that moves while `tmr_en` is low.

A wrong flag priority or a stray overflow set shows at `flag_ovf` and `irq_ovf` in the clock right after the wrap or load that caused it.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_GATED = 1'b1
  } pacc_mode_e;

  localparam int unsigned PACC_CNT_W   = 16;
  localparam int unsigned PACC_DIV     = 64;
  localparam int unsigned PACC_SYNC_ST = 2;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre <= '0;
    end else if (pre == LAST) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  assign tick = run && !restart && (pre == LAST);
endmodule

// File: rtl/pacc_flag.sv
module pacc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_n;

  assign flag_n = set | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n & ie;
    end
  end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pacc_pkg::*;
#(
  parameter int unsigned CNT_W   = PACC_CNT_W,
  parameter int unsigned DIV     = PACC_DIV,
  parameter int unsigned SYNC_ST = PACC_SYNC_ST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             acc_en,
  input  logic             mode_gate,
  input  logic             pol_sel,
  input  logic             ie_in,
  input  logic             ie_ovf,
  input  logic             tmr_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_in,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic             flag_in,
  output logic             flag_ovf,
  output logic             irq_in,
  output logic             irq_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  pacc_mode_e mode, mode_q;
  logic level, rise, fall;
  logic act_edge, trail_edge, gate_on;
  logic run, restart, tick;
  logic inc, wrap, in_set;

  assign mode = pacc_mode_e'(mode_gate);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_EDGE;
    else     mode_q <= mode;
  end

  pacc_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (pin_in),
    .level(level),
    .rise (rise),
    .fall (fall)
  );

  assign restart = (mode != mode_q);
  assign run     = acc_en & (mode == MODE_GATED) & tmr_en;

  pacc_prescale #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .restart(restart),
    .tick   (tick)
  );

  assign act_edge   = pol_sel ? rise : fall;
  assign trail_edge = pol_sel ? fall : rise;
  assign gate_on    = pol_sel ? level : ~level;

  always_comb begin
    inc    = 1'b0;
    in_set = 1'b0;
    if (acc_en) begin
      if (mode == MODE_GATED) begin
        inc    = tick & gate_on;
        in_set = trail_edge;
      end else begin
        inc    = act_edge;
        in_set = act_edge;
      end
    end
  end

  assign wrap = inc & ~cnt_wr & (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (cnt_wr) count <= cnt_wdata;
    else if (inc)    count <= count + 1'b1;
  end

  logic [1:0] f_set, f_clr, f_ie, f_flag, f_irq;
  assign f_set = {wrap, in_set};
  assign f_clr = {clr_ovf, clr_in};
  assign f_ie  = {ie_ovf, ie_in};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    pacc_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (f_set[g]),
      .clr (f_clr[g]),
      .ie  (f_ie[g]),
      .flag(f_flag[g]),
      .irq (f_irq[g])
    );
  end

  assign flag_in  = f_flag[0];
  assign flag_ovf = f_flag[1];
  assign irq_in   = f_irq[0];
  assign irq_ovf  = f_irq[1];
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] count,
  input logic             flag_in,
  input logic             flag_ovf,
  input logic             irq_in,
  input logic             irq_ovf
);
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !cnt_wr) |=> (count == $past(count))); // R9

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(cnt_wdata))); // R8

  AST_LOAD_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !flag_ovf) |=> !flag_ovf); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_wr) && count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1))); // R2

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!$past(cnt_wr) && $past(count) == '1 && count == '0) |-> flag_ovf); // R4

  AST_IRQ_IN_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_in |-> flag_in); // R10

  AST_IRQ_OVF_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> flag_ovf); // R10
endmodule

bind pulse_acc pacc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_en   (acc_en),
  .cnt_wr   (cnt_wr),
  .cnt_wdata(cnt_wdata),
  .count    (count),
  .flag_in  (flag_in),
  .flag_ovf (flag_ovf),
  .irq_in   (irq_in),
  .irq_ovf  (irq_ovf)
);

// File: tb/pulse_acc_bench.sv
module pulse_acc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0, acc_en = 1'b0, mode_gate = 1'b0, pol_sel = 1'b1;
  logic        ie_in = 1'b0, ie_ovf = 1'b0, tmr_en = 1'b0;
  logic        cnt_wr = 1'b0, clr_in = 1'b0, clr_ovf = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] count;
  logic        flag_in, flag_ovf, irq_in, irq_ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pulse_acc u_pulse_acc (
    .clk(clk), .rst(rst), .pin_in(pin_in), .acc_en(acc_en),
    .mode_gate(mode_gate), .pol_sel(pol_sel), .ie_in(ie_in), .ie_ovf(ie_ovf),
    .tmr_en(tmr_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .clr_in(clr_in), .clr_ovf(clr_ovf), .count(count),
    .flag_in(flag_in), .flag_ovf(flag_ovf), .irq_in(irq_in), .irq_ovf(irq_ovf)
  );

  // vector: {pol, enable, pulse count, expected count}
  typedef struct packed {
    logic       pol;
    logic       en;
    logic [7:0] n;
    logic [7:0] exp;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'd3, 8'd3},
    '{1'b0, 1'b1, 8'd5, 8'd5},
    '{1'b1, 1'b0, 8'd4, 8'd0},
    '{1'b0, 1'b1, 8'd1, 8'd1},
    '{1'b0, 1'b0, 8'd2, 8'd0},
    '{1'b1, 1'b1, 8'd7, 8'd7}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; step(1); cnt_wr = 1'b0;
  endtask

  task automatic clear_all();
    clr_in = 1'b1; clr_ovf = 1'b1; step(1); clr_in = 1'b0; clr_ovf = 1'b0;
  endtask

  task automatic pulse(input logic idle);
    pin_in = ~idle; step(4); pin_in = idle; step(4);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flags", {flag_in, flag_ovf, irq_in, irq_ovf}, 0);

    // Table walk: edge mode, timer disabled throughout (R2, R3, R9, R10)
    ie_in = 1'b1;
    for (int i = 0; i < NV; i++) begin
      acc_en = 1'b0; pol_sel = VECS[i].pol; pin_in = ~VECS[i].pol;
      step(5);
      load(16'd0);
      clear_all();
      acc_en = VECS[i].en;
      for (int p = 0; p < int'(VECS[i].n); p++) pulse(~VECS[i].pol);
      step(2);
      check(VECS[i].en ? "R2 edge count" : "R9 disabled hold", count, 32'(VECS[i].exp));
      check(VECS[i].en ? "R3 input flag" : "R9 no flag", flag_in, (VECS[i].exp != 0));
      check("R10 irq_in follows flag", irq_in, flag_in & ie_in);
    end

    // R11 latency: rising-edge mode, pin set low idle
    acc_en = 1'b1; pol_sel = 1'b1; pin_in = 1'b0; step(5);
    load(16'd20);
    pin_in = 1'b1; step(2);
    check("R11 not before third edge", count, 20);
    step(1);
    check("R11 after third edge", count, 21);
    pin_in = 1'b0; step(5);

    // R7 set wins over clear in the same cycle
    check("R7 flag set before", flag_in, 1);
    pin_in = 1'b1; step(2);
    clr_in = 1'b1; step(1); clr_in = 1'b0;
    check("R7 set wins", flag_in, 1);
    check("R2 counted", count, 22);
    pin_in = 1'b0; step(5);
    clr_in = 1'b1; step(1); clr_in = 1'b0;
    check("R7 cleared by write-one", flag_in, 0);
    ie_in = 1'b0;

    // R4 overflow
    ie_ovf = 1'b1;
    load(16'hFFFE); clear_all();
    pulse(1'b0);
    check("R4 no flag at FFFF", flag_ovf, 0);
    pulse(1'b0);
    check("R4 wrapped count", count, 0);
    check("R4 overflow flag", flag_ovf, 1);
    check("R10 irq_ovf with enable", irq_ovf, 1);
    ie_ovf = 1'b0; step(1);
    check("R10 irq_ovf masked", irq_ovf, 0);

    // R8 load does not set overflow
    clear_all();
    load(16'hFFFF); load(16'h0000);
    check("R8 load value", count, 0);
    check("R8 load no overflow", flag_ovf, 0);

    // R5 / R6 gated mode, high-active gate
    acc_en = 1'b1; mode_gate = 1'b1; pol_sel = 1'b1; tmr_en = 1'b0;
    pin_in = 1'b1; step(6);
    load(16'd0); clear_all();
    tmr_en = 1'b1;
    step(640);
    check("R5 gated ten ticks", count, 10);
    tmr_en = 1'b0; step(200);
    check("R5 hold while timer off", count, 10);
    check("R6 no flag during gate", flag_in, 0);
    pin_in = 1'b0; step(4);
    check("R6 trailing edge flag", flag_in, 1);
    tmr_en = 1'b1; step(300);
    check("R5 hold while gate inactive", count, 10);
    tmr_en = 1'b0;

    // R5 / R6 low-active gate
    pol_sel = 1'b0; step(4); clear_all();
    tmr_en = 1'b1; step(128);
    check("R5 low-active gate counts", count, 12);
    tmr_en = 1'b0;
    pin_in = 1'b1; step(4);
    check("R6 low-gate trailing flag", flag_in, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule